// File: doc/BRIEF.md
# Tile Cell Pixel Decoder

This block expands one character or tile cell into the eight horizontal pixels of the current display row. Each cell arrives as a 16-bit tilemap entry and the glyph row data already fetched for it. The block sends out one 8-bit colour index per accepted beat. Three pixel depths are supported. The 1-bit text mode takes its foreground and background colours from the entry. The 4-bit and 8-bit tile modes take per-tile horizontal and vertical mirroring and a 16-way palette bank from the entry. Two display controls act on the beat stream. Horizontal replication repeats every pixel up to four times. A fine scroll offset drops leading beats from the first cell of a line.

The block also works out, combinationally, which glyph and which glyph row the fetch logic must read for the entry it is currently offered. Vertical mirroring is applied there, before the glyph address exists. Cells come in on a valid/ready stream and pixels leave on another. A cell is accepted only when cell_ready is high. pix_index stays frozen for as long as pix_valid is high and pix_ready is low. The mode, replication and scroll pins are plain controls. They are captured when a cell is accepted, so changing them affects only later cells.

Top module: `tile_pixel_decoder`

## Requirements
- R1: After reset, pix_valid is low and cell_ready is high.
- R2: While pix_valid is high and pix_ready is low, pix_valid stays high and pix_index does not change on the next cycle. A beat transfers only when pix_valid and pix_ready are both high, and no beat is presented that does not belong to an accepted cell.
- R3: In mode 0 (1-bit), entry bits [11:8] are the foreground colour and [15:12] the background colour. Pixel i (i=0 leftmost) uses glyph bit 7-i. A set bit outputs {4'h0, foreground} and a clear bit outputs {4'h0, background}.
- R4: In mode 1 (4-bit), pixel i takes the nibble at glyph bits [31-4i:28-4i], and the output is {entry[15:12], nibble}.
- R5: In modes 2 and 3 (8-bit), pixel i takes the byte at glyph bits [63-8i:56-8i], and the output is that byte XOR {entry[15:12], 4'h0}.
- R6: In modes 1 to 3, entry bit 10 set reverses the pixel order within the row, so pixel i takes the slot of pixel 7-i. In mode 0, bit 10 acts only as part of the foreground colour.
- R7: fetch_glyph is {2'b00, cell_entry[7:0]} in mode 0 and cell_entry[9:0] otherwise. fetch_row is cell_row, except in mode 1 with cell_entry[11] set, where it is (cell_height - cell_row) mod 16. Here cell_height holds the displayed height minus one.
- R8: With replication code r, each pixel is sent on r+1 consecutive beats, so an unscrolled cell gives 8(r+1) beats.
- R9: A cell accepted with cell_first high drops its first min(fine_scroll, 8(r+1)-1) beats. Cells with cell_first low are never shortened.
- R10: When the next cell is offered by the time the current cell's final beat transfers, pix_valid stays high with no idle cycle between the two cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Pixel depth: 0 1-bit, 1 4-bit, 2/3 8-bit (captured per cell) |
| rep | input | 2 | Replication code, each pixel repeated rep+1 times (captured per cell) |
| fine_scroll | input | 5 | Leading beats dropped from a line-first cell (captured per cell) |
| cell_height | input | 4 | Displayed cell height minus one, used for vertical mirroring |
| cell_row | input | 4 | Row of the cell being fetched |
| fetch_glyph | output | 10 | Glyph index to fetch for cell_entry |
| fetch_row | output | 4 | Glyph row to fetch for cell_entry, mirrored where requested |
| cell_valid | input | 1 | Cell offered |
| cell_ready | output | 1 | Cell accepted when high together with cell_valid |
| cell_first | input | 1 | Cell is the first of a display line |
| cell_entry | input | 16 | Tilemap entry word |
| cell_glyph | input | 64 | Glyph row data, leftmost pixel in the most significant bits |
| pix_valid | output | 1 | Pixel beat available |
| pix_ready | input | 1 | Downstream takes the beat |
| pix_index | output | 8 | Colour index of the beat |

## Verification
Several rules are checked on every cycle. An output beat stays frozen under back-pressure. The upper nibble of the index is zero in text mode and equals the bank in 4-bit mode. The sub-pixel repeat counter never passes the replication count. Each cell ends after exactly 8(r+1) beats minus its scroll skip. Other behaviour can only be shown by the bench's scenarios against its behavioural model: the exact per-pixel bit and nibble ordering, mirror reversal, the XOR bank in 8-bit mode, the fetch row arithmetic, the scroll clamp at the end of a cell, and gap-free streaming across cells.

// File: rtl/tile_pkg.sv
package tile_pkg;

  localparam int ENTRY_W     = 16;
  localparam int GLYPH_IDX_W = 10;
  localparam int COLOR_W     = 4;
  localparam int INDEX_W     = 8;

  typedef enum logic [1:0] {
    MODE_TEXT1 = 2'd0,
    MODE_TILE4 = 2'd1,
    MODE_TILE8 = 2'd2,
    MODE_TILE8B = 2'd3
  } tile_mode_e;

  // Fields that shape the colour of each pixel, held for the whole cell
  typedef struct packed {
    logic               hmir;
    logic [COLOR_W-1:0] bank;
    logic [COLOR_W-1:0] fg;
    logic [COLOR_W-1:0] bg;
  } tile_paint_t;

endpackage

// File: rtl/tile_entry_decode.sv
module tile_entry_decode
  import tile_pkg::*;
#(
  parameter int ROW_W = 4
) (
  input  logic [ENTRY_W-1:0]     entry,
  input  tile_mode_e             mode,
  input  logic [ROW_W-1:0]       row,
  input  logic [ROW_W-1:0]       height_m1,
  output tile_paint_t            paint,
  output logic [GLYPH_IDX_W-1:0] glyph_idx,
  output logic [ROW_W-1:0]       glyph_row
);

  logic vmir;

  always_comb begin
    paint = '0;
    vmir  = 1'b0;
    if (mode == MODE_TEXT1) begin
      glyph_idx = {2'b00, entry[7:0]};
      paint.fg  = entry[11:8];
      paint.bg  = entry[15:12];
    end else begin
      glyph_idx  = entry[9:0];
      paint.hmir = entry[10];
      paint.bank = entry[15:12];
      // vertical flip only takes effect at 4 bits per pixel
      vmir = (mode == MODE_TILE4) && entry[11];
    end
    glyph_row = vmir ? (height_m1 - row) : row;
  end

endmodule

// File: rtl/tile_pixel_select.sv
module tile_pixel_select
  import tile_pkg::*;
#(
  parameter int CELL_PIX = 8,
  localparam int POS_W   = $clog2(CELL_PIX),
  localparam int GLYPH_W = CELL_PIX * 8
) (
  input  logic [GLYPH_W-1:0] glyph,
  input  tile_mode_e         mode,
  input  tile_paint_t        paint,
  input  logic [POS_W-1:0]   pos,
  output logic [INDEX_W-1:0] index
);

  logic [CELL_PIX-1:0] bit1;
  logic [3:0]          nib4 [CELL_PIX];
  logic [7:0]          byte8[CELL_PIX];

  // leftmost pixel sits in the most significant slice at every depth
  for (genvar i = 0; i < CELL_PIX; i++) begin : g_slice
    assign bit1[i]  = glyph[CELL_PIX-1-i];
    assign nib4[i]  = glyph[4*CELL_PIX-1-4*i -: 4];
    assign byte8[i] = glyph[8*CELL_PIX-1-8*i -: 8];
  end

  logic [POS_W-1:0] col;

  always_comb begin
    col = paint.hmir ? POS_W'(CELL_PIX - 1 - int'(pos)) : pos;
    unique case (mode)
      MODE_TEXT1: index = {4'h0, bit1[pos] ? paint.fg : paint.bg};
      MODE_TILE4: index = {paint.bank, nib4[col]};
      default:    index = byte8[col] ^ {paint.bank, 4'h0};
    endcase
  end

endmodule

// File: rtl/tile_beat_seq.sv
module tile_beat_seq #(
  parameter int CELL_PIX = 8,
  parameter int REP_W    = 2,
  parameter int SCROLL_W = 5,
  localparam int POS_W   = $clog2(CELL_PIX),
  localparam int BEAT_W  = POS_W + REP_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                first,
  input  logic [SCROLL_W-1:0] scroll,
  input  logic [REP_W-1:0]    rep,
  input  logic                adv,
  output logic                busy,
  output logic                last,
  output logic [POS_W-1:0]    pos
);

  logic [REP_W-1:0] sub, rep_q;
  logic [POS_W-1:0] start_pos;
  logic [REP_W-1:0] start_sub;
  logic [BEAT_W-1:0] skip;

  always_comb begin
    int f_i, tot_i, skip_i;
    f_i    = int'(rep) + 1;
    tot_i  = CELL_PIX * f_i;
    skip_i = 0;
    if (first) skip_i = (int'(scroll) > tot_i - 1) ? tot_i - 1 : int'(scroll);
    skip      = BEAT_W'(skip_i);
    start_pos = '0;
    for (int k = 0; k < CELL_PIX; k++) begin
      if (skip_i >= k * f_i) start_pos = POS_W'(k);
    end
    start_sub = REP_W'(skip_i - int'(start_pos) * f_i);
  end

  assign last = busy && (pos == POS_W'(CELL_PIX - 1)) && (sub == rep_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      pos   <= '0;
      sub   <= '0;
      rep_q <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      pos   <= start_pos;
      sub   <= start_sub;
      rep_q <= rep;
    end else if (adv) begin
      if (last) begin
        busy <= 1'b0;
      end else if (sub == rep_q) begin
        sub <= '0;
        pos <= pos + 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  // repeat counter stays inside the replication window
  assert_sub_range_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> (sub <= rep_q));

  // independent tally of beats sent for the cell in flight
  logic [BEAT_W:0]   beat_cnt;
  logic [BEAT_W-1:0] skip_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      beat_cnt <= '0;
      skip_q   <= '0;
    end else if (load) begin
      beat_cnt <= '0;
      skip_q   <= skip;
    end else if (adv) begin
      beat_cnt <= beat_cnt + 1'b1;
    end
  end

  assert_beat_total_R9: assert property (@(posedge clk) disable iff (rst)
    (adv && last) |-> (int'(beat_cnt) + 1 + int'(skip_q) == CELL_PIX * (int'(rep_q) + 1)));

endmodule

// File: rtl/tile_pixel_decoder.sv
module tile_pixel_decoder
  import tile_pkg::*;
#(
  parameter int CELL_PIX = 8,
  parameter int ROW_W    = 4,
  parameter int REP_W    = 2,
  parameter int SCROLL_W = 5,
  localparam int POS_W   = $clog2(CELL_PIX),
  localparam int GLYPH_W = CELL_PIX * 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             mode,
  input  logic [REP_W-1:0]       rep,
  input  logic [SCROLL_W-1:0]    fine_scroll,
  input  logic [ROW_W-1:0]       cell_height,
  input  logic [ROW_W-1:0]       cell_row,
  output logic [GLYPH_IDX_W-1:0] fetch_glyph,
  output logic [ROW_W-1:0]       fetch_row,
  input  logic                   cell_valid,
  output logic                   cell_ready,
  input  logic                   cell_first,
  input  logic [ENTRY_W-1:0]     cell_entry,
  input  logic [GLYPH_W-1:0]     cell_glyph,
  output logic                   pix_valid,
  input  logic                   pix_ready,
  output logic [INDEX_W-1:0]     pix_index
);

  tile_mode_e       mode_in, mode_q;
  tile_paint_t      paint_in, paint_q;
  logic [GLYPH_W-1:0] glyph_q;
  logic             busy, last, load, adv;
  logic [POS_W-1:0] pos;

  assign mode_in = tile_mode_e'(mode);

  tile_entry_decode #(.ROW_W(ROW_W)) u_decode (
    .entry(cell_entry), .mode(mode_in), .row(cell_row), .height_m1(cell_height),
    .paint(paint_in), .glyph_idx(fetch_glyph), .glyph_row(fetch_row)
  );

  assign pix_valid  = busy;
  assign adv        = pix_valid && pix_ready;
  assign cell_ready = !busy || (pix_ready && last);
  assign load       = cell_valid && cell_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_TEXT1;
      paint_q <= '0;
      glyph_q <= '0;
    end else if (load) begin
      mode_q  <= mode_in;
      paint_q <= paint_in;
      glyph_q <= cell_glyph;
    end
  end

  tile_beat_seq #(.CELL_PIX(CELL_PIX), .REP_W(REP_W), .SCROLL_W(SCROLL_W)) u_seq (
    .clk(clk), .rst(rst), .load(load), .first(cell_first), .scroll(fine_scroll),
    .rep(rep), .adv(adv), .busy(busy), .last(last), .pos(pos)
  );

  tile_pixel_select #(.CELL_PIX(CELL_PIX)) u_select (
    .glyph(glyph_q), .mode(mode_q), .paint(paint_q), .pos(pos), .index(pix_index)
  );

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pix_valid && cell_ready));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_index)));

  assert_text_upper_R3: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && mode_q == MODE_TEXT1) |-> (pix_index[7:4] == 4'h0));

  assert_bank_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && mode_q == MODE_TILE4) |-> (pix_index[7:4] == paint_q.bank));

endmodule

// File: tb/tile_pixel_decoder_bench.sv
module tile_pixel_decoder_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = '0;
  logic [1:0]  rep = '0;
  logic [4:0]  fine_scroll = '0;
  logic [3:0]  cell_height = '0;
  logic [3:0]  cell_row = '0;
  logic [9:0]  fetch_glyph;
  logic [3:0]  fetch_row;
  logic        cell_valid = 1'b0;
  logic        cell_ready;
  logic        cell_first = 1'b0;
  logic [15:0] cell_entry = '0;
  logic [63:0] cell_glyph = '0;
  logic        pix_valid;
  logic        pix_ready = 1'b1;
  logic [7:0]  pix_index;

  int checks = 0;
  int failures = 0;
  int ready_rand = 0;

  int    exp_v[$];
  string exp_t[$];
  logic  stall_prev = 1'b0;
  logic [7:0] stall_idx = '0;

  always #5 clk = ~clk;

  tile_pixel_decoder u_tile_pixel_decoder (
    .clk(clk), .rst(rst), .mode(mode), .rep(rep), .fine_scroll(fine_scroll),
    .cell_height(cell_height), .cell_row(cell_row), .fetch_glyph(fetch_glyph),
    .fetch_row(fetch_row), .cell_valid(cell_valid), .cell_ready(cell_ready),
    .cell_first(cell_first), .cell_entry(cell_entry), .cell_glyph(cell_glyph),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_index(pix_index)
  );

  function automatic int model_index(int m, logic [15:0] e, logic [63:0] g, int p);
    int c;
    if (m == 0) return g[7-p] ? int'(e[11:8]) : int'(e[15:12]);
    c = e[10] ? 7 - p : p;
    if (m == 1) return int'({e[15:12], g[31-4*c -: 4]});
    return int'(g[63-8*c -: 8] ^ {e[15:12], 4'h0});
  endfunction

  task automatic push_cell();
    int f, tot, skip;
    string tg;
    f = int'(rep) + 1;
    tot = 8 * f;
    skip = 0;
    if (cell_first) skip = (int'(fine_scroll) > tot - 1) ? tot - 1 : int'(fine_scroll);
    if (cell_first && fine_scroll != 0) tg = "R9";
    else if (rep != 0) tg = "R8";
    else if (mode != 0 && cell_entry[10]) tg = "R6";
    else if (mode == 0) tg = "R3";
    else if (mode == 1) tg = "R4";
    else tg = "R5";
    for (int b = skip; b < tot; b++) begin
      exp_v.push_back(model_index(int'(mode), cell_entry, cell_glyph, b / f));
      exp_t.push_back(tg);
    end
  endtask

  // reference comparison on every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (stall_prev) begin
        checks++;
        if (!pix_valid || pix_index !== stall_idx) begin
          failures++;
          $display("FAIL R2 hold: actual valid=%0b idx=%0d expected valid=1 idx=%0d",
                   pix_valid, pix_index, stall_idx);
        end
      end
      if (exp_v.size() > 0) begin
        checks++;
        if (!pix_valid) begin
          failures++;
          $display("FAIL R10 bubble: actual pix_valid=0 expected pix_valid=1");
        end
      end else if (pix_valid) begin
        checks++;
        failures++;
        $display("FAIL R2 stray beat: actual idx=%0d expected no beat", pix_index);
      end
      if (pix_valid && pix_ready && exp_v.size() > 0) begin
        int e;
        string t;
        e = exp_v.pop_front();
        t = exp_t.pop_front();
        checks++;
        if (int'(pix_index) != e) begin
          failures++;
          $display("FAIL %s pixel: actual=%0d expected=%0d", t, pix_index, e);
        end
      end
      stall_prev = pix_valid && !pix_ready;
      stall_idx  = pix_index;
      if (cell_valid && cell_ready) push_cell();
    end
  end

  always @(posedge clk) begin
    #1 pix_ready = (ready_rand != 0) ? 1'($urandom % 2) : 1'b1;
  end

  task automatic send_cell(logic [15:0] e, logic [63:0] g, logic f);
    cell_entry = e;
    cell_glyph = g;
    cell_first = f;
    cell_valid = 1'b1;
    @(negedge clk);
    while (!cell_ready) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic drain();
    @(negedge clk);
    while (exp_v.size() != 0 || pix_valid) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  // hm: 0 clear bit 10, 1 set bit 10, 2 random
  task automatic burst(int n, logic first_line, int hm);
    logic [15:0] e;
    for (int i = 0; i < n; i++) begin
      e = 16'($urandom);
      if (hm == 0) e[10] = 1'b0;
      if (hm == 1) e[10] = 1'b1;
      send_cell(e, {$urandom, $urandom}, first_line && (i == 0));
    end
    cell_valid = 1'b0;
    cell_first = 1'b0;
    drain();
  endtask

  task automatic cfg(int m, int r, int s, int rr);
    mode = 2'(m);
    rep = 2'(r);
    fine_scroll = 5'(s);
    ready_rand = rr;
  endtask

  task automatic check_fetch(int m, logic [15:0] e, int h, int r, int eg, int er);
    mode = 2'(m);
    cell_entry = e;
    cell_height = 4'(h);
    cell_row = 4'(r);
    @(negedge clk);
    checks++;
    if (int'(fetch_glyph) != eg || int'(fetch_row) != er) begin
      failures++;
      $display("FAIL R7 fetch: actual glyph=%0d row=%0d expected glyph=%0d row=%0d",
               fetch_glyph, fetch_row, eg, er);
    end
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (pix_valid !== 1'b0 || cell_ready !== 1'b1) begin
      failures++;
      $display("FAIL R1 reset: actual valid=%0b ready=%0b expected valid=0 ready=1",
               pix_valid, cell_ready);
    end
    @(posedge clk);
    #1;

    // R7 fetch address and vertical mirror
    check_fetch(0, 16'hFBA5, 7, 3, 16'hA5, 3);
    check_fetch(1, 16'h03C7, 7, 2, 16'h3C7, 2);
    check_fetch(1, 16'h0BC7, 7, 2, 16'h3C7, 5);
    check_fetch(1, 16'h0801, 15, 3, 1, 12);
    check_fetch(1, 16'h0801, 10, 12, 1, 14);
    check_fetch(2, 16'h0A12, 7, 2, 16'h212, 2);
    check_fetch(0, 16'h0812, 7, 2, 16'h12, 2);

    cfg(0, 0, 0, 0); burst(4, 1'b0, 2);   // R3, bit 10 inert in text mode (R6)
    cfg(1, 0, 0, 1); burst(6, 1'b0, 2);   // R4, R6
    cfg(2, 0, 0, 1); burst(5, 1'b0, 2);   // R5, R6
    cfg(3, 0, 0, 0); burst(3, 1'b0, 1);   // R5 alternate code, mirrored
    cfg(1, 1, 0, 1); burst(3, 1'b0, 2);   // R8
    cfg(2, 2, 0, 0); burst(3, 1'b0, 2);   // R8
    cfg(0, 3, 0, 1); burst(3, 1'b0, 2);   // R8
    cfg(2, 0, 3, 1); burst(3, 1'b1, 2);   // R9
    cfg(1, 2, 5, 0); burst(2, 1'b1, 2);   // R9 with replication
    cfg(0, 0, 31, 0); burst(2, 1'b1, 0);  // R9 clamp to final beat
    cfg(1, 3, 31, 1); burst(2, 1'b1, 1);  // R9 clamp under replication
    cfg(2, 0, 0, 0); burst(5, 1'b0, 2);   // R10 back-to-back cells

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule